// File: doc/BRIEF.md
# Reset Cause Controller

This block merges every reset request on a chip into one internal reset and remembers which request produced the latest reset. It takes requests from the supply (power-on), the external reset pad, the watchdog timeout, the missing-clock detector, a comparator output and a conversion-start pad. Every request except power-on passes through a two-flop synchronizer. The internal reset is stretched to a fixed length after the last holding request goes away, and its release is aligned to the clock.

Software reaches the block through an 8-bit register with a write path and a read path. Most bits mean different things in each direction. On a write, a bit turns a source on, or it forces a reset. On a read, the same bit reports whether that source caused the last reset. A forced power-on reset also pulls the external pad low. A software reset leaves the pad untouched. While the block is driving the pad, it ignores the pad as an input, so the reset cannot hold itself in place.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `porN` is low, `sysRstN` is low and `pinDriveLow` is high. After `porN` rises, a read returns 0x02.
- R2: `sysRstN` returns high exactly STRETCH_CYCLES (default 16) cycles after the last clock edge at which a holding request (a synchronized pad-low request or a watchdog-high request) is seen. With no holding request, a reset lasts exactly STRETCH_CYCLES cycles from entry.
- R3: The read layout is: bit 7 always 0, bit 6 conversion-start pad, bit 5 comparator, bit 4 software, bit 3 watchdog, bit 2 missing clock, bit 1 power-on, bit 0 external pad. Exactly one of these bits is 1, and the flags change only when a reset is entered.
- R4: Writing a value with bit 4 = 1 while running starts a reset whose cause reads 0x10, and `pinDriveLow` stays low. Bit 4 = 0 does nothing.
- R5: Writing a value with bit 1 = 1 while running starts a reset whose cause reads 0x02, with `pinDriveLow` high for the whole reset. The pad input is ignored while it is driven and for SYNC_STAGES cycles afterwards.
- R6: Writing bit 2, bit 5 or bit 6 as 1 enables, respectively, missing-clock (`mclkLost` high), comparator (`cmpOut` low) and conversion-start (`cnvPinN` low) as reset sources. Writing 0 disables them. A disabled source never causes a reset.
- R7: Entering any reset clears all three source enables.
- R8: When several requests arrive in the same cycle, the recorded cause follows this order: forced power-on, external pad, watchdog, missing clock, comparator, conversion-start, software.
- R9: An asynchronous request that changes just before a clock edge enters reset on the third rising edge. `sysRstN` is first seen low after that edge.
- R10: Register writes made while the internal reset is active are ignored.
- R11: A reset caused by the external pad reads 0x01. A reset caused by the watchdog reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on / supply-good, active low, asynchronous |
| pinRstN | input | 1 | Level seen at the external reset pad, active low |
| wdtTimeout | input | 1 | Watchdog timeout request, active high |
| mclkLost | input | 1 | Missing-clock detection, active high |
| cmpOut | input | 1 | Comparator output, reset request when low |
| cnvPinN | input | 1 | Conversion-start pad, reset request when low |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (cause flags) |
| sysRstN | output | 1 | Internal reset, active low |
| pinDriveLow | output | 1 | Open-drain pull-down enable for the reset pad |

## Verification
The bench sends every cause down the same path: software writes, forced power-on writes, pad pulses, watchdog levels, and enabled and disabled comparator, conversion-start and missing-clock inputs. Comparing the recorded cause for each one shows whether the bit positions and the enable gating are distinct. Requests that arrive together, and a write that sets both forcing bits, show whether the priority order is correct. A forced power-on reset has the pad looped back through the pull-down, so a pad mask that is too short shows up as the wrong cause or as a longer reset. A stimulus pulled one cycle before a clock edge pins down the synchronizer latency. Writes made during a reset show whether such writes are ignored.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  // bit positions in the cause/enable register
  localparam int unsigned BIT_PIN  = 0;
  localparam int unsigned BIT_POR  = 1;
  localparam int unsigned BIT_MCLK = 2;
  localparam int unsigned BIT_WDT  = 3;
  localparam int unsigned BIT_SW   = 4;
  localparam int unsigned BIT_CMP  = 5;
  localparam int unsigned BIT_CNV  = 6;
  localparam int unsigned NUM_CAUSE = 7;

  // positions in the synchronized request vector
  localparam int unsigned IDX_PIN  = 0;
  localparam int unsigned IDX_WDT  = 1;
  localparam int unsigned IDX_MCLK = 2;
  localparam int unsigned IDX_CMP  = 3;
  localparam int unsigned IDX_CNV  = 4;
  localparam int unsigned NUM_ASYNC = 5;

  typedef struct packed {
    logic                 enter;  // reset is entered at this edge
    logic [NUM_CAUSE-1:0] cause;  // one-hot cause of the entered reset
    logic                 wrEn;   // accepted register write
  } rsc_strobe_t;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int unsigned NUM    = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk,
  input  logic           porN,
  input  logic [NUM-1:0] rawIn,
  output logic [NUM-1:0] syncOut
);
  for (genvar i = 0; i < NUM; i++) begin : g_chain
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], rawIn[i]};
    end
    assign syncOut[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 16,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic [NUM_ASYNC-1:0] reqSync,
  input  logic                 mclkEn,
  input  logic                 cmpEn,
  input  logic                 cnvEn,
  input  logic                 wrEn,
  input  logic                 wrSw,
  input  logic                 wrPor,
  input  logic                 porFlag,
  output rsc_strobe_t          strobe,
  output logic                 active,
  output logic                 pinDrive
);
  localparam int unsigned CNT_W = (STRETCH_CYCLES > 2) ? $clog2(STRETCH_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYCLES - 1);

  logic [CNT_W-1:0]       cnt;
  logic [SYNC_STAGES-1:0] drvHist;
  logic                   pinMask;
  logic pinReq, wdtReq, mclkReq, cmpReq, cnvReq, swReq, porReq;
  logic hold, anyReq;
  logic [NUM_CAUSE-1:0]   causeOh;

  assign pinDrive = active & porFlag;
  // pad is ignored while we pull it and until the synchronizer has flushed
  assign pinMask  = pinDrive | (|drvHist);

  assign pinReq  = reqSync[IDX_PIN] & ~pinMask;
  assign wdtReq  = reqSync[IDX_WDT];
  assign mclkReq = reqSync[IDX_MCLK] & mclkEn;
  assign cmpReq  = reqSync[IDX_CMP] & cmpEn;
  assign cnvReq  = reqSync[IDX_CNV] & cnvEn;
  assign swReq   = wrEn & wrSw & ~active;
  assign porReq  = wrEn & wrPor & ~active;

  assign hold = pinReq | wdtReq | mclkReq | cmpReq | cnvReq;

  always_comb begin
    causeOh = '0;
    if (porReq)       causeOh[BIT_POR]  = 1'b1;
    else if (pinReq)  causeOh[BIT_PIN]  = 1'b1;
    else if (wdtReq)  causeOh[BIT_WDT]  = 1'b1;
    else if (mclkReq) causeOh[BIT_MCLK] = 1'b1;
    else if (cmpReq)  causeOh[BIT_CMP]  = 1'b1;
    else if (cnvReq)  causeOh[BIT_CNV]  = 1'b1;
    else if (swReq)   causeOh[BIT_SW]   = 1'b1;
  end
  assign anyReq = |causeOh;

  assign strobe.enter = ~active & anyReq;
  assign strobe.cause = causeOh;
  assign strobe.wrEn  = wrEn & ~active;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      active  <= 1'b1;
      cnt     <= LOAD;
      drvHist <= '0;
    end else begin
      drvHist <= {drvHist[SYNC_STAGES-2:0], pinDrive};
      if (!active) begin
        if (anyReq) begin
          active <= 1'b1;
          cnt    <= LOAD;
        end
      end else if (hold) begin
        cnt <= LOAD;
      end else if (cnt == '0) begin
        active <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R4
  enter_takes_chk: assert property (@(posedge clk) disable iff (!porN)
    strobe.enter |=> active);

  // R2
  release_quiet_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(active) |-> !$past(hold));

  // R8
  pin_over_internal_chk: assert property (@(posedge clk) disable iff (!porN)
    (strobe.enter && pinReq) |-> (strobe.cause[BIT_PIN] || strobe.cause[BIT_POR]));
endmodule

// File: rtl/rsc_dp.sv
module rsc_dp
  import rsc_pkg::*;
(
  input  logic                 clk,
  input  logic                 porN,
  input  rsc_strobe_t          strobe,
  input  logic                 wrMclk,
  input  logic                 wrCmp,
  input  logic                 wrCnv,
  output logic                 mclkEn,
  output logic                 cmpEn,
  output logic                 cnvEn,
  output logic                 porFlag,
  output logic [7:0]           rdData
);
  logic [NUM_CAUSE-1:0] flags;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      flags  <= NUM_CAUSE'(1 << BIT_POR);
      mclkEn <= 1'b0;
      cmpEn  <= 1'b0;
      cnvEn  <= 1'b0;
    end else if (strobe.enter) begin
      flags  <= strobe.cause;
      mclkEn <= 1'b0;
      cmpEn  <= 1'b0;
      cnvEn  <= 1'b0;
    end else if (strobe.wrEn) begin
      mclkEn <= wrMclk;
      cmpEn  <= wrCmp;
      cnvEn  <= wrCnv;
    end
  end

  assign porFlag = flags[BIT_POR];
  assign rdData  = {1'b0, flags};

  // R7
  enables_cleared_chk: assert property (@(posedge clk) disable iff (!porN)
    $past(strobe.enter) |-> (!mclkEn && !cmpEn && !cnvEn));

  // R3
  flags_stable_chk: assert property (@(posedge clk) disable iff (!porN)
    !$past(strobe.enter) |-> $stable(flags));

  // R3
  flags_single_chk: assert property (@(posedge clk) disable iff (!porN)
    $countones(flags) == 1);
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 16,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       pinRstN,
  input  logic       wdtTimeout,
  input  logic       mclkLost,
  input  logic       cmpOut,
  input  logic       cnvPinN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       sysRstN,
  output logic       pinDriveLow
);
  logic [NUM_ASYNC-1:0] rawReq, reqSync;
  rsc_strobe_t strobe;
  logic mclkEn, cmpEn, cnvEn, porFlag, active;
  logic unusedBits;

  assign unusedBits = ^{regWrData[7], regWrData[3], regWrData[0]};

  assign rawReq[IDX_PIN]  = ~pinRstN;
  assign rawReq[IDX_WDT]  = wdtTimeout;
  assign rawReq[IDX_MCLK] = mclkLost;
  assign rawReq[IDX_CMP]  = ~cmpOut;
  assign rawReq[IDX_CNV]  = ~cnvPinN;

  rsc_sync #(.NUM(NUM_ASYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .porN(porN), .rawIn(rawReq), .syncOut(reqSync)
  );

  rsc_ctrl #(.STRETCH_CYCLES(STRETCH_CYCLES), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .porN(porN), .reqSync(reqSync),
    .mclkEn(mclkEn), .cmpEn(cmpEn), .cnvEn(cnvEn),
    .wrEn(regWrEn), .wrSw(regWrData[BIT_SW]), .wrPor(regWrData[BIT_POR]),
    .porFlag(porFlag), .strobe(strobe), .active(active), .pinDrive(pinDriveLow)
  );

  rsc_dp dp_i (
    .clk(clk), .porN(porN), .strobe(strobe),
    .wrMclk(regWrData[BIT_MCLK]), .wrCmp(regWrData[BIT_CMP]), .wrCnv(regWrData[BIT_CNV]),
    .mclkEn(mclkEn), .cmpEn(cmpEn), .cnvEn(cnvEn),
    .porFlag(porFlag), .rdData(regRdData)
  );

  assign sysRstN = ~active;
endmodule

// File: tb/rst_cause_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb_top;
  localparam int STRETCH = 16;

  logic clk = 1'b0;
  logic porN = 1'b1;
  logic extPinN = 1'b1;
  logic wdtTimeout = 1'b0, mclkLost = 1'b0, cmpOut = 1'b1, cnvPinN = 1'b1;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic sysRstN, pinDriveLow, pinRstN;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  // pad is wired-AND of the external driver and the block's pull-down
  assign pinRstN = extPinN & ~pinDriveLow;

  rst_cause_ctrl dut_i (
    .clk(clk), .porN(porN), .pinRstN(pinRstN), .wdtTimeout(wdtTimeout),
    .mclkLost(mclkLost), .cmpOut(cmpOut), .cnvPinN(cnvPinN),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .sysRstN(sysRstN), .pinDriveLow(pinDriveLow)
  );

  // ---------------- behavioural reference ----------------
  bit mActive;
  int mCnt;
  bit [6:0] mFlags;
  bit mEnM, mEnC, mEnV;
  bit [4:0] s1, s2;
  bit h1, h2;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mActive = 1; mCnt = STRETCH - 1; mFlags = 7'h02;
      mEnM = 0; mEnC = 0; mEnV = 0; s1 = 0; s2 = 0; h1 = 0; h2 = 0;
    end else begin
      bit drv, pad, pinQ, wdtQ, mclkQ, cmpQ, cnvQ, wr, swQ, pfQ, holdQ;
      bit [4:0] raw;
      int cause;
      drv   = mActive & mFlags[1];
      pad   = extPinN & ~drv;
      raw   = {~cnvPinN, ~cmpOut, mclkLost, wdtTimeout, ~pad};
      pinQ  = s2[0] & ~(drv | h1 | h2);
      wdtQ  = s2[1];
      mclkQ = s2[2] & mEnM;
      cmpQ  = s2[3] & mEnC;
      cnvQ  = s2[4] & mEnV;
      wr    = regWrEn & ~mActive;
      swQ   = wr & regWrData[4];
      pfQ   = wr & regWrData[1];
      holdQ = pinQ | wdtQ | mclkQ | cmpQ | cnvQ;
      cause = -1;
      if (pfQ) cause = 1; else if (pinQ) cause = 0; else if (wdtQ) cause = 3;
      else if (mclkQ) cause = 2; else if (cmpQ) cause = 5; else if (cnvQ) cause = 6;
      else if (swQ) cause = 4;
      if (!mActive) begin
        if (cause >= 0) begin
          mActive = 1; mCnt = STRETCH - 1; mFlags = 7'(1 << cause);
          mEnM = 0; mEnC = 0; mEnV = 0;
        end else if (wr) begin
          mEnM = regWrData[2]; mEnC = regWrData[5]; mEnV = regWrData[6];
        end
      end else if (holdQ) mCnt = STRETCH - 1;
      else if (mCnt == 0) mActive = 0;
      else mCnt = mCnt - 1;
      h2 = h1; h1 = drv; s2 = s1; s1 = raw;
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    chk(sysRstN == !mActive, "R2 sysRstN", sysRstN, !mActive);
    chk(pinDriveLow == (mActive & mFlags[1]), "R5 pinDriveLow", pinDriveLow, mActive & mFlags[1]);
    chk(regRdData == {1'b0, mFlags}, "R3 read", regRdData, {1'b0, mFlags});
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog got=%0d exp=%0d", cyc, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic waitEnter();
    for (int i = 0; i < 10 && sysRstN; i++) @(negedge clk);
  endtask

  task automatic waitRun(output int lowCnt, output bit sawDrv);
    lowCnt = 0; sawDrv = 0;
    while (!sysRstN) begin
      lowCnt++; sawDrv |= pinDriveLow;
      @(negedge clk);
    end
    idle(4);
  endtask

  initial begin
    int n;
    bit d;
    #1 porN = 1'b0;
    idle(4);
    // R1
    chk(sysRstN == 0, "R1 reset held", sysRstN, 0);
    chk(pinDriveLow == 1, "R1 pad driven", pinDriveLow, 1);
    porN = 1'b1;
    waitRun(n, d);
    chk(n == STRETCH, "R2 power-on length", n, STRETCH);
    chk(regRdData == 8'h02, "R1 power-on cause", regRdData, 8'h02);

    // R4 software reset
    wrReg(8'h10);
    waitRun(n, d);
    chk(n == STRETCH, "R2 software length", n, STRETCH);
    chk(d == 0, "R4 pad untouched", d, 0);
    chk(regRdData == 8'h10, "R4 software cause", regRdData, 8'h10);
    wrReg(8'h00); idle(3);
    chk(sysRstN == 1, "R4 zero write", sysRstN, 1);

    // R11 pad and watchdog
    @(negedge clk); extPinN = 1'b0; idle(6); extPinN = 1'b1;
    waitEnter(); waitRun(n, d);
    chk(regRdData == 8'h01, "R11 pad cause", regRdData, 8'h01);
    @(negedge clk); wdtTimeout = 1'b1;
    @(negedge clk); chk(sysRstN == 1, "R9 one edge", sysRstN, 1);
    @(negedge clk); chk(sysRstN == 1, "R9 two edges", sysRstN, 1);
    @(negedge clk); chk(sysRstN == 0, "R9 three edges", sysRstN, 0);
    wdtTimeout = 1'b0;
    waitRun(n, d);
    chk(regRdData == 8'h08, "R11 watchdog cause", regRdData, 8'h08);

    // R6 disabled, then enabled missing clock
    @(negedge clk); mclkLost = 1'b1; idle(5);
    chk(sysRstN == 1, "R6 disabled mclk", sysRstN, 1);
    mclkLost = 1'b0;
    wrReg(8'h04); idle(3);
    @(negedge clk); mclkLost = 1'b1; waitEnter(); mclkLost = 1'b0; waitRun(n, d);
    chk(regRdData == 8'h04, "R6 mclk cause", regRdData, 8'h04);
    // R7 enable cleared by that reset
    @(negedge clk); mclkLost = 1'b1; idle(5);
    chk(sysRstN == 1, "R7 mclk cleared", sysRstN, 1);
    mclkLost = 1'b0; idle(3);

    // R6 comparator and conversion-start
    wrReg(8'h20); @(negedge clk); cmpOut = 1'b0; waitEnter(); cmpOut = 1'b1; waitRun(n, d);
    chk(regRdData == 8'h20, "R6 cmp cause", regRdData, 8'h20);
    wrReg(8'h40); @(negedge clk); cnvPinN = 1'b0; waitEnter(); cnvPinN = 1'b1; waitRun(n, d);
    chk(regRdData == 8'h40, "R6 cnv cause", regRdData, 8'h40);

    // R5 forced power-on with pad looped back
    wrReg(8'h02);
    waitRun(n, d);
    chk(n == STRETCH, "R5 forced length", n, STRETCH);
    chk(d == 1, "R5 pad driven", d, 1);
    chk(regRdData == 8'h02, "R5 forced cause", regRdData, 8'h02);
    idle(3);
    chk(sysRstN == 1, "R5 no pad echo", sysRstN, 1);

    // R8 priority
    @(negedge clk); extPinN = 1'b0; wdtTimeout = 1'b1; idle(3);
    extPinN = 1'b1; wdtTimeout = 1'b0; waitEnter(); waitRun(n, d);
    chk(regRdData == 8'h01, "R8 pad over watchdog", regRdData, 8'h01);
    wrReg(8'h12); waitRun(n, d);
    chk(regRdData == 8'h02, "R8 forced over software", regRdData, 8'h02);

    // R10 write during reset ignored
    @(negedge clk); regWrEn = 1'b1; regWrData = 8'h10;
    @(negedge clk); regWrData = 8'h20;
    @(negedge clk); regWrEn = 1'b0; regWrData = 8'h00;
    waitRun(n, d);
    @(negedge clk); cmpOut = 1'b0; idle(5);
    chk(sysRstN == 1, "R10 write in reset", sysRstN, 1);
    chk(regRdData == 8'h10, "R10 cause kept", regRdData, 8'h10);
    cmpOut = 1'b1; idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule